// File: doc/BRIEF.md
# Two-Level Priority Event Scheduler

This block chooses the next event for one consumer. The consumer can draw from up to eight internal queues. Each queue holds events at eight priority levels. The scheduler receives one occupancy flag for each (queue, level) pair. It also receives an enable for each connection and a priority for each connection. From these it decides which queue and which level the consumer serves next.

The decision has two stages. The first stage takes the enabled, non-empty queue with the best connection priority. Ties at that priority are shared round-robin. The second stage takes the best occupied level inside that queue. A grant counter with a programmable period makes every Nth grant take the next lower occupied level instead. This keeps low-priority events from starving. A grant is requested by holding `ready_i` high, and the result appears on registered outputs one clock later.

Top module: `evsched_two_level`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant_vld_o` is 0.
- R2: A grant appears on `grant_vld_o` exactly one cycle after a cycle in which `ready_i` was 1 and at least one queue was eligible. It is 0 one cycle after any cycle in which `ready_i` was 0.
- R3: A queue is eligible only if its connection enable bit is 1 and at least one of its occupancy flags is 1. A disabled queue with occupied levels is never granted. With no eligible queue, no grant is issued.
- R4: Among eligible queues, the one with the numerically smallest 3-bit connection priority in `qprio_i[3q+2:3q]` is granted. Value 0 is the best priority.
- R5: Ties among eligible queues with equal best priority are resolved round-robin. The search starts at the queue after the last granted one. After reset the search starts at queue 0.
- R6: Occupancy of queue q, level l is bit `occ_i[8q+l]`. On a normal grant, `grant_lvl_o` is the smallest occupied level index of the granted queue, with level 0 as the best.
- R7: On every Nth grant, counted since reset or since the last period write, the level is the next occupied level above the smallest one in index order. If the queue has only one occupied level, that level is granted.
- R8: N is 100 after reset. A cycle with `period_wr_i` = 1 loads N from `period_i` and restarts the grant count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ready_i | input | 1 | Consumer requests a grant this cycle |
| conn_en_i | input | 8 | Connection enable, one bit per queue |
| qprio_i | input | 24 | Connection priority, 3 bits per queue, 0 best |
| occ_i | input | 64 | Occupancy flag per queue and level, bit 8q+l |
| period_wr_i | input | 1 | Load a new starvation period |
| period_i | input | 8 | Starvation period N |
| grant_vld_o | output | 1 | Grant valid |
| grant_q_o | output | 3 | Granted queue index |
| grant_lvl_o | output | 3 | Granted event level |

## Verification
A stale round-robin pointer does not show until the next grant among tied queues. That grant names the wrong queue, one grant after the fault. A corrupted grant counter shows only at the next starvation slot, so the bench compares every grant across a full default period. This catches a period or count error when its level appears up to N grants late. Faults in the selection stages show on the very next grant as a wrong queue index or a wrong level.

// File: rtl/evsched_pkg.sv
`timescale 1ns/1ps
package evsched_pkg;
    parameter int unsigned EVS_NQ         = 8;
    parameter int unsigned EVS_NLVL       = 8;
    parameter int unsigned EVS_PW         = 3;
    parameter int unsigned EVS_PERIOD_W   = 8;
    parameter int unsigned EVS_PERIOD_RST = 100;
endpackage

// File: rtl/evsched_qsel.sv
`timescale 1ns/1ps
// Stage one: best connection priority, round-robin among ties.
module evsched_qsel #(
    parameter int unsigned NQ = evsched_pkg::EVS_NQ,
    parameter int unsigned PW = evsched_pkg::EVS_PW,
    localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0]    elig_i,
    input  logic [NQ*PW-1:0] prio_i,
    input  logic [QW-1:0]    last_i,
    output logic             any_o,
    output logic [QW-1:0]    sel_o
);
    logic [PW-1:0] best;
    logic [NQ-1:0] cand;
    logic          found;

    always_comb begin
        best = '1;
        for (int q = 0; q < NQ; q++) begin
            if (elig_i[q] && (prio_i[q*PW +: PW] < best)) begin
                best = prio_i[q*PW +: PW];
            end
        end
        for (int q = 0; q < NQ; q++) begin
            cand[q] = elig_i[q] && (prio_i[q*PW +: PW] == best);
        end
    end

    always_comb begin
        sel_o = last_i;
        found = 1'b0;
        for (int k = 1; k <= NQ; k++) begin
            int idx;
            idx = (int'(last_i) + k) % NQ;
            if (!found && cand[idx]) begin
                sel_o = QW'(idx);
                found = 1'b1;
            end
        end
        any_o = |elig_i;
    end
endmodule

// File: rtl/evsched_lsel.sv
`timescale 1ns/1ps
// Stage two: best occupied level, or the next one when starvation fires.
module evsched_lsel #(
    parameter int unsigned NLVL = evsched_pkg::EVS_NLVL,
    localparam int unsigned LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic [NLVL-1:0] occ_i,
    input  logic            starve_i,
    output logic [LW-1:0]   lvl_o
);
    logic [LW-1:0] prim;
    logic [LW-1:0] alt;
    logic          has_prim;
    logic          has_alt;

    always_comb begin
        prim     = '0;
        alt      = '0;
        has_prim = 1'b0;
        has_alt  = 1'b0;
        for (int l = 0; l < NLVL; l++) begin
            if (occ_i[l]) begin
                if (!has_prim) begin
                    prim     = LW'(l);
                    has_prim = 1'b1;
                end else if (!has_alt) begin
                    alt      = LW'(l);
                    has_alt  = 1'b1;
                end
            end
        end
        lvl_o = (starve_i && has_alt) ? alt : prim;
    end
endmodule

// File: rtl/evsched_starve.sv
`timescale 1ns/1ps
// Grant counter that marks every Nth grant as a starvation pick.
module evsched_starve #(
    parameter int unsigned PERIOD_W   = evsched_pkg::EVS_PERIOD_W,
    parameter int unsigned PERIOD_RST = evsched_pkg::EVS_PERIOD_RST
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [PERIOD_W-1:0] val_i,
    input  logic                grant_i,
    output logic                fire_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PERIOD_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = (PERIOD_W+1)'(st_q.cnt) + (PERIOD_W+1)'(1);
        fire_o  = cnt_inc >= (PERIOD_W+1)'(st_q.period);
        if (wr_i) begin
            st_d.period = val_i;
            st_d.cnt    = '0;
        end else if (grant_i) begin
            st_d.cnt = fire_o ? '0 : cnt_inc[PERIOD_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.period <= PERIOD_W'(PERIOD_RST);
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/evsched_two_level.sv
`timescale 1ns/1ps
module evsched_two_level #(
    parameter int unsigned NQ         = evsched_pkg::EVS_NQ,
    parameter int unsigned NLVL       = evsched_pkg::EVS_NLVL,
    parameter int unsigned PW         = evsched_pkg::EVS_PW,
    parameter int unsigned PERIOD_W   = evsched_pkg::EVS_PERIOD_W,
    parameter int unsigned PERIOD_RST = evsched_pkg::EVS_PERIOD_RST,
    localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int unsigned LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ready_i,
    input  logic [NQ-1:0]       conn_en_i,
    input  logic [NQ*PW-1:0]    qprio_i,
    input  logic [NQ*NLVL-1:0]  occ_i,
    input  logic                period_wr_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                grant_vld_o,
    output logic [QW-1:0]       grant_q_o,
    output logic [LW-1:0]       grant_lvl_o
);
    typedef struct packed {
        logic          vld;
        logic [QW-1:0] q;
        logic [LW-1:0] lvl;
        logic [QW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    logic [NQ-1:0]   elig;
    logic            any_elig;
    logic [QW-1:0]   q_sel;
    logic [NLVL-1:0] occ_sel;
    logic [LW-1:0]   lvl_sel;
    logic            grant;
    logic            starve;

    for (genvar q = 0; q < NQ; q++) begin : g_elig
        assign elig[q] = conn_en_i[q] && (|occ_i[q*NLVL +: NLVL]);
    end

    evsched_qsel #(.NQ(NQ), .PW(PW)) u_qsel (
        .elig_i (elig),
        .prio_i (qprio_i),
        .last_i (st_q.last),
        .any_o  (any_elig),
        .sel_o  (q_sel)
    );

    assign occ_sel = occ_i[q_sel*NLVL +: NLVL];

    evsched_lsel #(.NLVL(NLVL)) u_lsel (
        .occ_i    (occ_sel),
        .starve_i (starve),
        .lvl_o    (lvl_sel)
    );

    evsched_starve #(.PERIOD_W(PERIOD_W), .PERIOD_RST(PERIOD_RST)) u_starve (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (period_wr_i),
        .val_i   (period_i),
        .grant_i (grant),
        .fire_o  (starve)
    );

    always_comb begin
        grant    = ready_i && any_elig;
        st_d     = st_q;
        st_d.vld = grant;
        if (grant) begin
            st_d.q    = q_sel;
            st_d.lvl  = lvl_sel;
            st_d.last = q_sel;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.vld  <= 1'b0;
            st_q.q    <= '0;
            st_q.lvl  <= '0;
            st_q.last <= QW'(NQ - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld_o = st_q.vld;
    assign grant_q_o   = st_q.q;
    assign grant_lvl_o = st_q.lvl;
endmodule

// File: rtl/evsched_chk.sv
`timescale 1ns/1ps
module evsched_chk #(
    parameter int unsigned NQ       = evsched_pkg::EVS_NQ,
    parameter int unsigned NLVL     = evsched_pkg::EVS_NLVL,
    parameter int unsigned PW       = evsched_pkg::EVS_PW,
    parameter int unsigned PERIOD_W = evsched_pkg::EVS_PERIOD_W,
    localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int unsigned LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                ready_i,
    input logic [NQ-1:0]       conn_en_i,
    input logic [NQ*PW-1:0]    qprio_i,
    input logic [NQ*NLVL-1:0]  occ_i,
    input logic                period_wr_i,
    input logic [PERIOD_W-1:0] period_i,
    input logic                grant_vld_o,
    input logic [QW-1:0]       grant_q_o,
    input logic [LW-1:0]       grant_lvl_o
);
    logic               rdy_p;
    logic               any_p;
    logic [NQ-1:0]      en_p;
    logic [NQ*PW-1:0]   prio_p;
    logic [NQ*NLVL-1:0] occ_p;
    logic               any_now;
    logic [NLVL-1:0]    gq_occ;
    logic               better;
    logic [NLVL-1:0]    below;
    logic               side_unused;

    always_comb begin
        any_now = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (conn_en_i[q] && (|occ_i[q*NLVL +: NLVL])) any_now = 1'b1;
        end
        side_unused = period_wr_i ^ (|period_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdy_p  <= 1'b0;
            any_p  <= 1'b0;
            en_p   <= '0;
            prio_p <= '0;
            occ_p  <= '0;
        end else begin
            rdy_p  <= ready_i;
            any_p  <= any_now;
            en_p   <= conn_en_i;
            prio_p <= qprio_i;
            occ_p  <= occ_i;
        end
    end

    always_comb begin
        gq_occ = occ_p[grant_q_o*NLVL +: NLVL];
        better = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (en_p[q] && (|occ_p[q*NLVL +: NLVL]) &&
                (prio_p[q*PW +: PW] < prio_p[grant_q_o*PW +: PW])) better = 1'b1;
        end
        for (int l = 0; l < NLVL; l++) begin
            below[l] = gq_occ[l] && (l < int'(grant_lvl_o));
        end
    end

    AST_GRANT_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> rdy_p); // R2
    AST_NO_MISSED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdy_p && any_p) |-> grant_vld_o); // R2
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> (en_p[grant_q_o] && gq_occ[grant_lvl_o])); // R3
    AST_BEST_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> !better); // R4
    AST_LEVEL_SKIP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> ($countones(below) <= 1)); // R7
    AST_SIDE_INPUTS_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown(side_unused)); // R8
endmodule

bind evsched_two_level evsched_chk #(
    .NQ(NQ), .NLVL(NLVL), .PW(PW), .PERIOD_W(PERIOD_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_i),
    .conn_en_i   (conn_en_i),
    .qprio_i     (qprio_i),
    .occ_i       (occ_i),
    .period_wr_i (period_wr_i),
    .period_i    (period_i),
    .grant_vld_o (grant_vld_o),
    .grant_q_o   (grant_q_o),
    .grant_lvl_o (grant_lvl_o)
);

// File: tb/evsched_two_level_tb.sv
`timescale 1ns/1ps
module evsched_two_level_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready = 1'b0;
    logic [7:0]  conn_en = '0;
    logic [23:0] qprio = '0;
    logic [63:0] occ = '0;
    logic        period_wr = 1'b0;
    logic [7:0]  period_val = '0;
    logic        grant_vld_o;
    logic [2:0]  grant_q_o;
    logic [2:0]  grant_lvl_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    evsched_two_level u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ready_i     (ready),
        .conn_en_i   (conn_en),
        .qprio_i     (qprio),
        .occ_i       (occ),
        .period_wr_i (period_wr),
        .period_i    (period_val),
        .grant_vld_o (grant_vld_o),
        .grant_q_o   (grant_q_o),
        .grant_lvl_o (grant_lvl_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_grant(input string tag, input bit ev, input int eq, input int el);
        ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ready = 1'b0;
        chk(tag, "vld", int'(grant_vld_o), int'(ev));
        if (ev) begin
            chk(tag, "queue", int'(grant_q_o), eq);
            chk(tag, "level", int'(grant_lvl_o), el);
        end
    endtask

    task automatic set_period(input int v);
        period_wr  = 1'b1;
        period_val = 8'(v);
        @(posedge clk);
        @(negedge clk);
        period_wr  = 1'b0;
    endtask

    task automatic all_prio(input int p);
        for (int q = 0; q < 8; q++) qprio[q*3 +: 3] = 3'(p);
    endtask

    // R1, R5 start point, R8 default period with R7 at grant 100
    task automatic t_reset_and_default;
        @(negedge clk);
        chk("R1", "vld in reset", int'(grant_vld_o), 0);
        rst_n = 1'b1;
        chk("R1", "vld after reset", int'(grant_vld_o), 0);
        conn_en = 8'hFF;
        all_prio(4);
        for (int q = 0; q < 8; q++) begin
            occ[q*8 + 0] = 1'b1;
            occ[q*8 + 3] = 1'b1;
        end
        for (int i = 0; i < 100; i++) begin
            do_grant((i == 99) ? "R8" : "R5", 1'b1, i % 8, (i == 99) ? 3 : 0);
        end
        set_period(200);
    endtask

    // R2: no grant without ready, grant drops after ready falls
    task automatic t_ready;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2", "vld without ready", int'(grant_vld_o), 0);
        end
        do_grant("R2", 1'b1, 4, 0);
        @(negedge clk);
        chk("R2", "vld after ready low", int'(grant_vld_o), 0);
    endtask

    // R3: disabled connections and empty queues
    task automatic t_eligible;
        occ = '0;
        occ[2*8 + 1] = 1'b1;
        conn_en = 8'hFB;
        do_grant("R3", 1'b0, 0, 0);
        occ = '0;
        conn_en = 8'hFF;
        do_grant("R3", 1'b0, 0, 0);
        occ[2*8 + 1] = 1'b1;
        do_grant("R3", 1'b1, 2, 1);
    endtask

    // R4: numerically smallest queue priority wins
    task automatic t_prio;
        occ = '0;
        occ[1*8] = 1'b1;
        occ[3*8] = 1'b1;
        occ[6*8] = 1'b1;
        qprio[1*3 +: 3] = 3'd5;
        qprio[3*3 +: 3] = 3'd7;
        qprio[6*3 +: 3] = 3'd2;
        do_grant("R4", 1'b1, 6, 0);
        qprio[3*3 +: 3] = 3'd0;
        do_grant("R4", 1'b1, 3, 0);
        all_prio(4);
    endtask

    // R5: round-robin among ties, after last granted queue 3
    task automatic t_rr;
        occ = '0;
        occ[2*8] = 1'b1;
        occ[5*8] = 1'b1;
        occ[7*8] = 1'b1;
        do_grant("R5", 1'b1, 5, 0);
        do_grant("R5", 1'b1, 7, 0);
        do_grant("R5", 1'b1, 2, 0);
        do_grant("R5", 1'b1, 5, 0);
    endtask

    // R6: best occupied level in the chosen queue
    task automatic t_level;
        occ = '0;
        occ[4*8 + 5] = 1'b1;
        occ[4*8 + 2] = 1'b1;
        occ[4*8 + 6] = 1'b1;
        do_grant("R6", 1'b1, 4, 2);
        occ = '0;
        occ[4*8 + 7] = 1'b1;
        do_grant("R6", 1'b1, 4, 7);
    endtask

    // R7 with a short period loaded through R8 write
    task automatic t_starve;
        set_period(3);
        occ = '0;
        occ[1*8 + 1] = 1'b1;
        occ[1*8 + 4] = 1'b1;
        do_grant("R7", 1'b1, 1, 1);
        do_grant("R7", 1'b1, 1, 1);
        do_grant("R7", 1'b1, 1, 4);
        do_grant("R7", 1'b1, 1, 1);
        do_grant("R7", 1'b1, 1, 1);
        do_grant("R7", 1'b1, 1, 4);
        occ = '0;
        occ[1*8 + 2] = 1'b1;
        do_grant("R7", 1'b1, 1, 2);
        do_grant("R7", 1'b1, 1, 2);
        do_grant("R7", 1'b1, 1, 2);
        set_period(200);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_and_default();
        t_ready();
        t_eligible();
        t_prio();
        t_rr();
        t_level();
        t_starve();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule